// File: doc/BRIEF.md
# Time-Stamp Aging Table Purger

This block keeps a small table of address entries. Each entry carries a key, a valid bit and an 8-bit age tag. Two 8-bit wrapping counters set the age: a "current" counter, whose value is stamped into every new entry, and a "purge" counter, which trails behind it. An accepted step advances both counters together. The table is then swept one entry per clock, and every valid entry whose tag equals the new purge value is dropped. An entry therefore survives for as many steps as the gap between the two counters was when it was written.

A step comes from the rising edge of an external strobe, and it counts only when both bits of a two-bit enable field are set. Two single-counter commands advance one counter at a time. The purge command also launches a sweep. While a sweep runs, the block reports busy and refuses any new step, command or insert. A registered read port lets the surrounding logic inspect any slot.

Top module: `stamp_age_table`

## Requirements
- R1: After synchronous reset both counters read 0, no entry is valid, and busy and full are low.
- R2: A rising edge on `step_strobe` is accepted when `cfg_en == 2'b11` and busy is low. On the accepting clock edge, both counters advance by one, wrapping modulo 256. A strobe held high for several cycles counts once.
- R3: A strobe rise while either bit of `cfg_en` is clear changes neither counter and starts no sweep.
- R4: On each clock with busy low, `cmd_adv_cur` high advances only the current counter. The current counter advances by one in total if a strobe is accepted on the same edge. `cmd_adv_purge` high advances only the purge counter and starts a sweep, unless a strobe is accepted on the same edge. Both commands are ignored while busy is high.
- R5: After an accepted step or purge command, busy is high for exactly DEPTH-1 cycles. By the DEPTH-th edge, counting the accepting edge as the first, every valid entry whose tag equals the new purge value has been cleared. Every other entry is kept.
- R6: A strobe rise that falls while busy is high is discarded. A rise arriving DEPTH cycles after the previously accepted one is accepted.
- R7: An insert (`ins_valid` high) writes `ins_key`, together with the current counter value as it stood before that edge, into the lowest-index free slot. That slot reads as valid after the edge.
- R8: An insert is ignored when full is high, when busy is high, or when a sweep starts on the same edge.
- R9: `full` is high exactly when all DEPTH slots are valid. It updates on the same edge as the valid bits, so it falls once a sweep frees a slot.
- R10: The read port returns `rd_valid`, `rd_key` and `rd_stamp` for slot `rd_idx` one cycle after `rd_idx` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 2 | Strobe enable field; both bits must be set |
| step_strobe | input | 1 | Step request, rising-edge sensitive |
| cmd_adv_cur | input | 1 | Advance the current counter alone |
| cmd_adv_purge | input | 1 | Advance the purge counter alone and sweep |
| ins_valid | input | 1 | Insert request |
| ins_key | input | KEY_W | Key to insert |
| rd_idx | input | IDX_W | Slot to read |
| rd_valid | output | 1 | Valid bit of the slot read |
| rd_key | output | KEY_W | Key of the slot read |
| rd_stamp | output | 8 | Age tag of the slot read |
| busy | output | 1 | Sweep in progress |
| full | output | 1 | All slots valid |
| valid_vec | output | DEPTH | Valid bit per slot |
| cur_stamp | output | 8 | Current counter |
| purge_stamp | output | 8 | Purge counter |

## Verification
The hardest situation to reach is a sweep that must remove some entries and keep others. That needs entries written under different current values while the purge counter still lags. The stimulus builds this with current-only commands between inserts, and then closes the gap one step at a time. A second hard case is a table that is exactly full with mixed tags. It is reached by filling half the slots, advancing the current counter, and filling the rest. Purge commands then walk the purge counter up until only the older half disappears. Requests that land inside a sweep, and a strobe spaced exactly DEPTH cycles after the previous one, are timed edge by edge from the accepting edge.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  localparam int STAMP_W = 8;
  typedef logic [STAMP_W-1:0] stamp_t;
endpackage

// File: rtl/sat_stamp_ctl.sv
`timescale 1ns/1ps
// Counter pair, strobe edge detection and sweep sequencer.
module sat_stamp_ctl
  import sat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_en,
  input  logic             step_strobe,
  input  logic             cmd_adv_cur,
  input  logic             cmd_adv_purge,
  output stamp_t           cur_q,
  output stamp_t           purge_q,
  output logic             busy_q,
  output logic             start,
  output logic             scan_en,
  output logic [IDX_W-1:0] scan_idx,
  output stamp_t           scan_ref
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic             strb_q;
  logic [IDX_W-1:0] idx_q;
  logic             rise;
  logic             strobe_go;
  logic             purge_go;
  logic             cur_go;

  always_comb begin
    rise      = step_strobe & ~strb_q;
    strobe_go = rise & (&cfg_en) & ~busy_q;
    purge_go  = cmd_adv_purge & ~busy_q & ~strobe_go;
    cur_go    = cmd_adv_cur & ~busy_q & ~strobe_go;
    start     = strobe_go | purge_go;
    // the first slot is swept on the accepting edge against the new value
    scan_en   = start | busy_q;
    scan_idx  = start ? '0 : idx_q;
    scan_ref  = start ? purge_q + 1'b1 : purge_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q  <= 1'b0;
      cur_q   <= '0;
      purge_q <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      strb_q <= step_strobe;
      if (strobe_go | cur_go) cur_q <= cur_q + 1'b1;
      if (start) purge_q <= purge_q + 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(1);
      end else if (busy_q) begin
        if (idx_q == LAST) busy_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_free_enc.sv
`timescale 1ns/1ps
// Lowest-index free slot finder.
module sat_free_enc #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] valid_vec,
  output logic [IDX_W-1:0] slot
);
  always_comb begin
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_vec[i]) slot = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sat_entry_store.sv
`timescale 1ns/1ps
// Key and tag arrays, valid bits, sweep compare and registered read port.
module sat_entry_store
  import sat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int KEY_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_go,
  input  logic [IDX_W-1:0] ins_slot,
  input  logic [KEY_W-1:0] ins_key,
  input  stamp_t           ins_stamp,
  input  logic             scan_en,
  input  logic [IDX_W-1:0] scan_idx,
  input  stamp_t           scan_ref,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DEPTH-1:0] valid_q,
  output logic             full_q,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output stamp_t           rd_stamp
);
  logic [KEY_W-1:0] key_mem   [DEPTH];
  stamp_t           stamp_mem [DEPTH];
  logic [DEPTH-1:0] valid_nxt;
  logic             hit;

  always_comb begin
    hit       = scan_en && valid_q[scan_idx] && (stamp_mem[scan_idx] == scan_ref);
    valid_nxt = valid_q;
    if (ins_go) valid_nxt[ins_slot] = 1'b1;
    if (hit) valid_nxt[scan_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      full_q  <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      full_q  <= &valid_nxt;
    end
  end

  // arrays without reset so they can map to RAM
  always_ff @(posedge clk) begin
    if (ins_go) begin
      key_mem[ins_slot]   <= ins_key;
      stamp_mem[ins_slot] <= ins_stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= valid_q[rd_idx];
    rd_key   <= key_mem[rd_idx];
    rd_stamp <= stamp_mem[rd_idx];
  end
endmodule

// File: rtl/stamp_age_table.sv
`timescale 1ns/1ps
module stamp_age_table
  import sat_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int KEY_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_en,
  input  logic             step_strobe,
  input  logic             cmd_adv_cur,
  input  logic             cmd_adv_purge,
  input  logic             ins_valid,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output logic [7:0]       rd_stamp,
  output logic             busy,
  output logic             full,
  output logic [DEPTH-1:0] valid_vec,
  output logic [7:0]       cur_stamp,
  output logic [7:0]       purge_stamp
);
  stamp_t           cur_w, purge_w, scan_ref, rd_stamp_w;
  logic             start, scan_en, ins_go;
  logic [IDX_W-1:0] scan_idx, free_slot;

  sat_stamp_ctl #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .step_strobe(step_strobe),
    .cmd_adv_cur(cmd_adv_cur), .cmd_adv_purge(cmd_adv_purge),
    .cur_q(cur_w), .purge_q(purge_w), .busy_q(busy), .start(start),
    .scan_en(scan_en), .scan_idx(scan_idx), .scan_ref(scan_ref)
  );

  sat_free_enc #(.DEPTH(DEPTH)) enc_i (
    .valid_vec(valid_vec), .slot(free_slot)
  );

  assign ins_go = ins_valid & ~full & ~busy & ~start;

  sat_entry_store #(.DEPTH(DEPTH), .KEY_W(KEY_W)) store_i (
    .clk(clk), .rst(rst), .ins_go(ins_go), .ins_slot(free_slot),
    .ins_key(ins_key), .ins_stamp(cur_w), .scan_en(scan_en),
    .scan_idx(scan_idx), .scan_ref(scan_ref), .rd_idx(rd_idx),
    .valid_q(valid_vec), .full_q(full), .rd_valid(rd_valid),
    .rd_key(rd_key), .rd_stamp(rd_stamp_w)
  );

  assign cur_stamp   = cur_w;
  assign purge_stamp = purge_w;
  assign rd_stamp    = rd_stamp_w;
endmodule

// File: rtl/sat_checker.sv
`timescale 1ns/1ps
module sat_checker #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_en,
  input logic             cmd_adv_purge,
  input logic             busy,
  input logic             full,
  input logic [DEPTH-1:0] valid_vec,
  input logic [7:0]       cur_stamp,
  input logic [7:0]       purge_stamp
);
  a_r2_cur_step: assert property (@(posedge clk) disable iff (rst)
    (cur_stamp != $past(cur_stamp)) |-> (cur_stamp == $past(cur_stamp) + 8'd1));

  a_r2_purge_step: assert property (@(posedge clk) disable iff (rst)
    (purge_stamp != $past(purge_stamp)) |-> (purge_stamp == $past(purge_stamp) + 8'd1));

  a_r3_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (cfg_en != 2'b11 && !cmd_adv_purge) |=> (purge_stamp == $past(purge_stamp)));

  a_r4_purge_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> (purge_stamp == $past(purge_stamp)));

  a_r4_cur_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cur_stamp == $past(cur_stamp)));

  a_r8_no_grow_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(valid_vec) <= $countones($past(valid_vec))));

  a_r7_single_insert: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($countones(valid_vec) <= $countones($past(valid_vec)) + 1));

  a_r9_full_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (full == (&valid_vec)));
endmodule

bind stamp_age_table sat_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cmd_adv_purge(cmd_adv_purge),
  .busy(busy), .full(full), .valid_vec(valid_vec),
  .cur_stamp(cur_stamp), .purge_stamp(purge_stamp)
);

// File: tb/stamp_age_table_tb_top.sv
`timescale 1ns/1ps
module stamp_age_table_tb_top;
  localparam int DEPTH = 8;
  localparam int KEY_W = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_en = 2'b11;
  logic             step_strobe = 1'b0;
  logic             cmd_adv_cur = 1'b0;
  logic             cmd_adv_purge = 1'b0;
  logic             ins_valid = 1'b0;
  logic [KEY_W-1:0] ins_key = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic             rd_valid, busy, full;
  logic [KEY_W-1:0] rd_key;
  logic [7:0]       rd_stamp, cur_stamp, purge_stamp;
  logic [DEPTH-1:0] valid_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_cur = 0;
  int m_pur = 0;

  always #2.5 clk = ~clk;

  stamp_age_table #(.DEPTH(DEPTH), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .step_strobe(step_strobe),
    .cmd_adv_cur(cmd_adv_cur), .cmd_adv_purge(cmd_adv_purge),
    .ins_valid(ins_valid), .ins_key(ins_key), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_key(rd_key), .rd_stamp(rd_stamp),
    .busy(busy), .full(full), .valid_vec(valid_vec),
    .cur_stamp(cur_stamp), .purge_stamp(purge_stamp)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ctr(input string tag);
    chk({tag, " cur"}, 32'(cur_stamp), 32'(m_cur & 255));
    chk({tag, " purge"}, 32'(purge_stamp), 32'(m_pur & 255));
  endtask

  task automatic pulse_strobe();
    step_strobe = 1'b1;
    tick();
    step_strobe = 1'b0;
  endtask

  task automatic do_insert(input logic [KEY_W-1:0] k);
    ins_valid = 1'b1;
    ins_key   = k;
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic read_slot(input int idx);
    rd_idx = IDX_W'(idx);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 cur", 32'(cur_stamp), 0);
    chk("R1 purge", 32'(purge_stamp), 0);
    chk("R1 valid", 32'(valid_vec), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 full", 32'(full), 0);
  endtask

  task automatic t_cur_cmd();
    repeat (3) begin
      cmd_adv_cur = 1'b1;
      tick();
      cmd_adv_cur = 1'b0;
      tick();
    end
    m_cur = 3;
    chk_ctr("R4 cur-only command");
    chk("R4 no sweep", 32'(busy), 0);
  endtask

  task automatic t_insert();
    do_insert(16'h1000);
    do_insert(16'h1001);
    do_insert(16'h1002);
    chk("R7 slots 0..2", 32'(valid_vec), 32'h07);
    read_slot(1);
    chk("R10 R7 key", 32'(rd_key), 32'h1001);
    chk("R7 stamp", 32'(rd_stamp), 3);
    cmd_adv_cur = 1'b1;
    tick();
    cmd_adv_cur = 1'b0;
    m_cur = 4;
    do_insert(16'h2000);
    read_slot(3);
    chk("R10 valid", 32'(rd_valid), 1);
    chk("R7 stamp slot3", 32'(rd_stamp), 4);
  endtask

  task automatic t_strobe_sweep();
    for (int s = 0; s < 3; s++) begin
      pulse_strobe();
      m_cur++;
      m_pur++;
      chk_ctr("R2 step");
      chk("R5 busy on", 32'(busy), 1);
      repeat (DEPTH - 2) tick();
      chk("R5 busy still", 32'(busy), 1);
      tick();
      chk("R5 busy off", 32'(busy), 0);
    end
    chk("R5 tag-3 entries swept", 32'(valid_vec), 32'h08);
  endtask

  task automatic t_lowest_free();
    do_insert(16'h3000);
    chk("R7 lowest free", 32'(valid_vec), 32'h09);
    read_slot(0);
    chk("R7 reuse key", 32'(rd_key), 32'h3000);
    chk("R7 reuse stamp", 32'(rd_stamp), 32'(m_cur));
  endtask

  task automatic t_disabled();
    cfg_en = 2'b01;
    pulse_strobe();
    repeat (DEPTH) tick();
    cfg_en = 2'b10;
    pulse_strobe();
    repeat (DEPTH) tick();
    cfg_en = 2'b11;
    chk_ctr("R3 gate closed");
    chk("R3 entries kept", 32'(valid_vec), 32'h09);
  endtask

  task automatic t_held();
    step_strobe = 1'b1;
    repeat (5) tick();
    step_strobe = 1'b0;
    repeat (DEPTH) tick();
    m_cur++;
    m_pur++;
    chk_ctr("R2 held strobe once");
    chk("R5 tag-4 swept", 32'(valid_vec), 32'h01);
  endtask

  task automatic t_busy_ignore();
    pulse_strobe();
    m_cur++;
    m_pur++;
    tick();
    step_strobe   = 1'b1;
    cmd_adv_cur   = 1'b1;
    cmd_adv_purge = 1'b1;
    ins_valid     = 1'b1;
    ins_key       = 16'hBEEF;
    tick();
    step_strobe   = 1'b0;
    cmd_adv_cur   = 1'b0;
    cmd_adv_purge = 1'b0;
    ins_valid     = 1'b0;
    repeat (DEPTH) tick();
    chk_ctr("R6 R4 requests during sweep");
    chk("R8 insert during sweep", 32'(valid_vec), 32'h01);
  endtask

  task automatic t_spacing();
    pulse_strobe();
    m_cur++;
    m_pur++;
    repeat (DEPTH - 1) tick();
    chk("R6 idle before next", 32'(busy), 0);
    pulse_strobe();
    m_cur++;
    m_pur++;
    chk_ctr("R6 spacing DEPTH accepted");
    chk("R6 busy again", 32'(busy), 1);
    repeat (DEPTH) tick();
    chk("R5 tag-7 swept", 32'(valid_vec), 32'h00);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) do_insert(KEY_W'(16'h4000 + i));
    cmd_adv_cur = 1'b1;
    tick();
    cmd_adv_cur = 1'b0;
    m_cur++;
    for (int i = 4; i < 8; i++) do_insert(KEY_W'(16'h4000 + i));
    chk("R9 full set", 32'(full), 1);
    do_insert(16'h5555);
    chk("R8 no insert when full", 32'(valid_vec), 32'hFF);
    read_slot(0);
    chk("R8 slot0 key kept", 32'(rd_key), 32'h4000);
    for (int p = 0; p < 4; p++) begin
      cmd_adv_purge = 1'b1;
      tick();
      cmd_adv_purge = 1'b0;
      m_pur++;
      repeat (DEPTH) tick();
      if (p == 2) chk("R9 still full", 32'(full), 1);
    end
    chk_ctr("R4 purge-only command");
    chk("R5 older half swept", 32'(valid_vec), 32'hF0);
    chk("R9 full cleared", 32'(full), 0);
    read_slot(0);
    chk("R10 freed slot", 32'(rd_valid), 0);
    read_slot(5);
    chk("R10 kept slot stamp", 32'(rd_stamp), 32'(m_cur & 255));
  endtask

  task automatic t_wrap();
    cmd_adv_cur = 1'b1;
    repeat (256 - (m_cur & 255)) tick();
    cmd_adv_cur = 1'b0;
    m_cur = 0;
    chk_ctr("R2 wrap");
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_cur_cmd();
    t_insert();
    t_strobe_sweep();
    t_lowest_free();
    t_disabled();
    t_held();
    t_busy_ignore();
    t_spacing();
    t_full();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule